// File: doc/BRIEF.md
# Shift-and-AND Triplet Finder

This block searches for straight-line triplets among hits on three detector planes. Planes A and C are the outer planes and plane B is the centre plane. A straight track crossing all three satisfies xA + xC = 2·xB. An event is handled in two passes. In the first pass each outer-plane hit sets one bit in a position-indexed bit array, at one hit per clock. In the second pass the centre-plane hits arrive one per clock. For each centre hit the stored C pattern is shifted by an amount that depends on the centre coordinate and is then ANDed bit-wise with the A pattern. Every surviving bit is a valid triplet.

The C pattern is held with its bit order reversed. This turns the opposite-sign relation between xA and xC into a plain right shift followed by an aligned AND. The shift is built as a logarithmic barrel shifter, so a single bank of coincidence logic serves every centre hit. For each centre hit the block reports one result record a fixed two cycles later. The record holds the centre coordinate, the lowest matching A coordinate with its partner C coordinate, a found flag and the number of matches. A clear input empties both arrays between events.

Top module: `tf_triplet_finder`

## Requirements
- R1: After reset `trip_vld` is 0 and both bit arrays are empty, so a centre hit presented straight after reset reports `trip_found`=0 and `trip_cnt`=0.
- R2: A hit with `hit_plane`=0 (plane A) or `hit_plane`=2 (plane C) that is accepted at a clock edge takes part in any centre hit presented from the next cycle on.
- R3: A centre hit (`hit_plane`=1) accepted at clock edge k produces `trip_vld`=1 just after edge k+2 and not earlier, with `trip_pos_b` equal to the centre coordinate. Consecutive centre hits produce consecutive results.
- R4: A stored pair (a, c) matches a centre coordinate b exactly when a + c = 2·b. `trip_pos_a` is the lowest matching a, and `trip_pos_c` = 2·b − a.
- R5: `trip_cnt` equals the number of stored A positions a that have a stored C hit at 2·b − a, and `trip_found` is 1 exactly when that number is nonzero.
- R6: When nothing matches, the result still has `trip_vld`=1, with `trip_found`=0 and `trip_cnt`=0.
- R7: Positions that fall outside 0..63 after the shift count as empty. At b=0 only the pair (0,0) can match, and at b=63 only the pair (63,63) can match.
- R8: `clr`=1 empties both arrays at the next edge. An outer hit presented in the same cycle as `clr` is dropped.
- R9: A hit with `hit_plane`=3 changes no array.
- R10: `trip_vld` is 0 in every cycle that does not follow a centre hit by two edges.
- R11: Loading the same outer position twice has the same effect as loading it once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Empty both outer-plane arrays |
| hit_vld | input | 1 | Hit present this cycle |
| hit_plane | input | 2 | Plane code: 0 = A, 1 = B (centre), 2 = C, 3 = none |
| hit_pos | input | 6 | Hit coordinate 0..63 |
| trip_vld | output | 1 | Result record valid |
| trip_found | output | 1 | At least one triplet matched |
| trip_pos_a | output | 6 | Lowest matching A coordinate |
| trip_pos_b | output | 6 | Centre coordinate of this result |
| trip_pos_c | output | 6 | C coordinate paired with `trip_pos_a` |
| trip_cnt | output | 7 | Number of matching pairs |

## Verification
The hardest cases to reach are matches at the ends of the shift range. At b=0 the shift moves almost the whole C pattern out of the window, and at b=63 only the last position survives. These are the places where a shifter that wraps or is off by one would make up or lose a pair. The vector table loads single pairs at the corners (0,0), (63,63), (1,63) and (63,1), and adds odd-sum pairs that must never match. A denser event then loads four matching pairs and one decoy, and sends two centre hits back to back. This checks that the count, the lowest-A selection and the one-record-per-hit pipeline all hold together.

// File: rtl/tf_pkg.sv
package tf_pkg;
  typedef enum logic [1:0] {
    PL_A    = 2'd0,
    PL_B    = 2'd1,
    PL_C    = 2'd2,
    PL_NONE = 2'd3
  } plane_e;
endpackage

// File: rtl/tf_bit_store.sv
module tf_bit_store #(
  parameter int POS_W = 6,
  localparam int NPOS = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hit_vld,
  input  logic [1:0]       hit_plane,
  input  logic [POS_W-1:0] hit_pos,
  output logic [NPOS-1:0]  arr_a,
  output logic [NPOS-1:0]  arr_c_rev
);
  import tf_pkg::*;

  plane_e pl;
  assign pl = plane_e'(hit_plane);

  logic [POS_W-1:0] rev_idx;
  assign rev_idx = POS_W'(NPOS - 1) - hit_pos;

  // plane A kept in natural order
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      arr_a <= '0;
    end else if (hit_vld && pl == PL_A) begin
      arr_a[hit_pos] <= 1'b1;
    end
  end

  // plane C kept mirrored so the match becomes a shift plus AND
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      arr_c_rev <= '0;
    end else if (hit_vld && pl == PL_C) begin
      arr_c_rev[rev_idx] <= 1'b1;
    end
  end

  // R8: clear empties both arrays, also when a hit comes along
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (arr_a == '0 && arr_c_rev == '0));

  // R9: unused plane code leaves the arrays alone
  p_ignore_none_r9: assert property (@(posedge clk) disable iff (rst)
    (hit_vld && pl == PL_NONE && !clr) |=> ($stable(arr_a) && $stable(arr_c_rev)));

  // R2: a centre hit never alters stored outer patterns
  p_centre_no_store_r2: assert property (@(posedge clk) disable iff (rst)
    (hit_vld && pl == PL_B && !clr) |=> ($stable(arr_a) && $stable(arr_c_rev)));
endmodule

// File: rtl/tf_barrel.sv
module tf_barrel #(
  parameter int W    = 128,
  parameter int SH_W = 7
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] sh,
  output logic [W-1:0]    dout
);
  logic [W-1:0] stage [SH_W+1];

  assign stage[0] = din;

  for (genvar g = 0; g < SH_W; g++) begin : g_stage
    localparam int AMT = 1 << g;
    assign stage[g+1] = sh[g] ? (stage[g] >> AMT) : stage[g];
  end

  assign dout = stage[SH_W];
endmodule

// File: rtl/tf_pick.sv
module tf_pick #(
  parameter int POS_W = 6,
  localparam int NPOS  = 1 << POS_W,
  localparam int CNT_W = POS_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [POS_W-1:0] in_b,
  input  logic [NPOS-1:0]  in_mask,
  output logic             out_vld,
  output logic             out_found,
  output logic [POS_W-1:0] out_a,
  output logic [POS_W-1:0] out_b,
  output logic [POS_W-1:0] out_c,
  output logic [CNT_W-1:0] out_cnt
);
  logic [POS_W-1:0] low_idx;
  logic             any_set;
  logic [CNT_W-1:0] ones;

  // lowest set bit wins
  always_comb begin
    low_idx = '0;
    any_set = 1'b0;
    for (int i = NPOS - 1; i >= 0; i--) begin
      if (in_mask[i]) begin
        low_idx = POS_W'(i);
        any_set = 1'b1;
      end
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < NPOS; i++) begin
      ones = ones + CNT_W'(in_mask[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      out_found <= 1'b0;
      out_a     <= '0;
      out_b     <= '0;
      out_c     <= '0;
      out_cnt   <= '0;
    end else begin
      out_vld   <= in_vld;
      out_found <= in_vld && any_set;
      out_a     <= low_idx;
      out_b     <= in_b;
      out_c     <= POS_W'({in_b, 1'b0} - {1'b0, low_idx});
      out_cnt   <= in_vld ? ones : '0;
    end
  end

  // R5: flag and count come from separate reductions and must agree
  p_found_matches_cnt_r5: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_found == (out_cnt != '0)));

  // R4: reported pair lies on the line through the centre hit
  p_pair_on_line_r4: assert property (@(posedge clk) disable iff (rst)
    out_found |-> (({1'b0, out_a} + {1'b0, out_c}) == {out_b, 1'b0}));

  // R10: nothing is reported without a valid record
  p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (!out_found && out_cnt == '0));
endmodule

// File: rtl/tf_triplet_finder.sv
module tf_triplet_finder #(
  parameter int POS_W = 6,
  localparam int NPOS  = 1 << POS_W,
  localparam int EXT   = 2 * NPOS,
  localparam int SH_W  = POS_W + 1,
  localparam int CNT_W = POS_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hit_vld,
  input  logic [1:0]       hit_plane,
  input  logic [POS_W-1:0] hit_pos,
  output logic             trip_vld,
  output logic             trip_found,
  output logic [POS_W-1:0] trip_pos_a,
  output logic [POS_W-1:0] trip_pos_b,
  output logic [POS_W-1:0] trip_pos_c,
  output logic [CNT_W-1:0] trip_cnt
);
  import tf_pkg::*;

  localparam logic [SH_W-1:0] SH_TOP = SH_W'(EXT - 1);

  logic [NPOS-1:0] arr_a;
  logic [NPOS-1:0] arr_c_rev;

  tf_bit_store #(.POS_W(POS_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .hit_vld   (hit_vld),
    .hit_plane (hit_plane),
    .hit_pos   (hit_pos),
    .arr_a     (arr_a),
    .arr_c_rev (arr_c_rev)
  );

  logic b_hit;
  assign b_hit = hit_vld && (plane_e'(hit_plane) == PL_B);

  // mirrored C sits in the upper half; below it zeros fill the window
  logic [EXT-1:0]  c_ext;
  logic [EXT-1:0]  c_shifted;
  logic [SH_W-1:0] sh_amt;

  assign c_ext  = {arr_c_rev, {NPOS{1'b0}}};
  assign sh_amt = SH_TOP - {hit_pos, 1'b0};

  tf_barrel #(.W(EXT), .SH_W(SH_W)) u_shift (
    .din  (c_ext),
    .sh   (sh_amt),
    .dout (c_shifted)
  );

  logic             m_vld;
  logic [POS_W-1:0] m_b;
  logic [NPOS-1:0]  m_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_vld  <= 1'b0;
      m_b    <= '0;
      m_mask <= '0;
    end else begin
      m_vld  <= b_hit;
      m_b    <= hit_pos;
      m_mask <= b_hit ? (arr_a & c_shifted[NPOS-1:0]) : '0;
    end
  end

  tf_pick #(.POS_W(POS_W)) u_pick (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (m_vld),
    .in_b      (m_b),
    .in_mask   (m_mask),
    .out_vld   (trip_vld),
    .out_found (trip_found),
    .out_a     (trip_pos_a),
    .out_b     (trip_pos_b),
    .out_c     (trip_pos_c),
    .out_cnt   (trip_cnt)
  );

  // R3: each centre hit yields a record two edges later
  p_result_latency_r3: assert property (@(posedge clk) disable iff (rst)
    b_hit |=> ##1 trip_vld);

  // R3: the record carries the centre coordinate that was presented
  p_centre_echo_r3: assert property (@(posedge clk) disable iff (rst)
    b_hit |=> ##1 (trip_pos_b == $past(hit_pos, 2)));

  // R10: no record without a centre hit
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
    !b_hit |=> ##1 !trip_vld);
endmodule

// File: tb/tf_triplet_finder_tb_top.sv
module tf_triplet_finder_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic       hit_vld = 1'b0;
  logic [1:0] hit_plane = 2'd0;
  logic [5:0] hit_pos = 6'd0;
  logic       trip_vld, trip_found;
  logic [5:0] trip_pos_a, trip_pos_b, trip_pos_c;
  logic [6:0] trip_cnt;

  always #2 clk = ~clk;

  tf_triplet_finder dut_i (
    .clk(clk), .rst(rst), .clr(clr), .hit_vld(hit_vld), .hit_plane(hit_plane),
    .hit_pos(hit_pos), .trip_vld(trip_vld), .trip_found(trip_found),
    .trip_pos_a(trip_pos_a), .trip_pos_b(trip_pos_b), .trip_pos_c(trip_pos_c),
    .trip_cnt(trip_cnt)
  );

  int total = 0;
  int bad   = 0;
  bit [63:0] ma = '0;
  bit [63:0] mc = '0;

  // {a, c, b, found, lowest a, count}
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    {6'd10, 6'd20, 6'd15, 1'b1, 6'd10, 7'd1},
    {6'd10, 6'd21, 6'd15, 1'b0, 6'd0,  7'd0},
    {6'd0,  6'd0,  6'd0,  1'b1, 6'd0,  7'd1},
    {6'd63, 6'd63, 6'd63, 1'b1, 6'd63, 7'd1},
    {6'd0,  6'd63, 6'd31, 1'b0, 6'd0,  7'd0},
    {6'd1,  6'd63, 6'd32, 1'b1, 6'd1,  7'd1},
    {6'd63, 6'd1,  6'd32, 1'b1, 6'd63, 7'd1},
    {6'd40, 6'd0,  6'd20, 1'b1, 6'd40, 7'd1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input int b, output int f, output int la, output int n);
    f = 0; la = 0; n = 0;
    for (int a = 63; a >= 0; a--) begin
      int c = 2 * b - a;
      if (c >= 0 && c < 64 && ma[a] && mc[c]) begin
        n++; la = a; f = 1;
      end
    end
  endtask

  task automatic load(input int pl, input int pos);
    hit_vld = 1'b1; hit_plane = 2'(pl); hit_pos = 6'(pos);
    @(negedge clk);
    hit_vld = 1'b0;
    if (pl == 0) ma[pos] = 1'b1;
    if (pl == 2) mc[pos] = 1'b1;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    ma = '0; mc = '0;
  endtask

  // centre hit; compares the record with the bench model
  task automatic centre(input int b, input string tag);
    int f, la, n;
    model(b, f, la, n);
    hit_vld = 1'b1; hit_plane = 2'd1; hit_pos = 6'(b);
    @(negedge clk);
    hit_vld = 1'b0;
    chk({"R3 early ", tag}, int'(trip_vld), 0);
    @(negedge clk);
    chk({"R3 vld ", tag}, int'(trip_vld), 1);
    chk({"R3 posb ", tag}, int'(trip_pos_b), b);
    chk({"R5 found ", tag}, int'(trip_found), f);
    chk({"R5 cnt ", tag}, int'(trip_cnt), n);
    if (f != 0) begin
      chk({"R4 posa ", tag}, int'(trip_pos_a), la);
      chk({"R4 posc ", tag}, int'(trip_pos_c), 2 * b - la);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R3 watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset vld", int'(trip_vld), 0);
    centre(15, "R1 empty after reset");

    // vector table walk: single pair per event (R2, R4, R6, R7)
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v = VEC[i];
      do_clear();
      load(0, int'(v[31:26]));
      load(2, int'(v[25:20]));
      hit_vld = 1'b1; hit_plane = 2'd1; hit_pos = v[19:14];
      @(negedge clk);
      hit_vld = 1'b0;
      @(negedge clk);
      chk("R3 table vld", int'(trip_vld), 1);
      chk("R6 R7 table found", int'(trip_found), int'(v[13]));
      chk("R5 table cnt", int'(trip_cnt), int'(v[6:0]));
      if (v[13]) chk("R4 R7 table lowest a", int'(trip_pos_a), int'(v[12:7]));
    end

    // dense event: four pairs on b=15 plus a decoy
    do_clear();
    load(0, 5); load(0, 10); load(0, 20); load(0, 30);
    load(2, 25); load(2, 20); load(2, 10); load(2, 0); load(2, 3);
    centre(15, "R5 dense");
    chk("R5 dense count value", int'(trip_cnt), 4);
    chk("R4 dense lowest", int'(trip_pos_a), 5);

    // R11: repeat load is idempotent
    load(0, 5); load(2, 25);
    centre(15, "R11 dup");
    chk("R11 dup count", int'(trip_cnt), 4);

    // back-to-back centre hits, then idle (R3, R10)
    hit_vld = 1'b1; hit_plane = 2'd1; hit_pos = 6'd15;
    @(negedge clk);
    hit_pos = 6'd12;
    @(negedge clk);
    hit_vld = 1'b0;
    chk("R3 b2b first", int'(trip_pos_b), 15);
    chk("R3 b2b first cnt", int'(trip_cnt), 4);
    @(negedge clk);
    chk("R3 b2b second vld", int'(trip_vld), 1);
    chk("R3 b2b second", int'(trip_pos_b), 12);
    @(negedge clk);
    chk("R10 idle vld", int'(trip_vld), 0);

    // R9: unused plane code stores nothing
    do_clear();
    load(2, 20);
    load(3, 10);
    centre(15, "R9 ignored");
    chk("R9 no match", int'(trip_found), 0);

    // R8: clear wins over a simultaneous outer hit
    load(0, 10);
    clr = 1'b1; hit_vld = 1'b1; hit_plane = 2'd0; hit_pos = 6'd12;
    @(negedge clk);
    clr = 1'b0; hit_vld = 1'b0;
    ma = '0; mc = '0;
    load(2, 20); load(2, 18);
    centre(15, "R8 after clear");
    chk("R8 dropped hit", int'(trip_cnt), 0);
    load(0, 10);
    centre(15, "R2 reload");
    chk("R2 reload found", int'(trip_found), 1);

    // R7: edges of the shift window
    do_clear();
    load(0, 0); load(0, 63); load(2, 0); load(2, 63); load(2, 62);
    centre(0, "R7 b0");
    chk("R7 b0 count", int'(trip_cnt), 1);
    centre(63, "R7 b63");
    chk("R7 b63 count", int'(trip_cnt), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule